// File: doc/BRIEF.md
# Peripheral Interrupt Aggregator

The aggregator collects thirty-two peripheral interrupt lines into one request toward the processor. Each line has one status bit and one enable bit. Most status bits simply mirror their input line. Two positions, 10 (serial transmit done) and 11 (serial receive done), are sticky: a rising edge on the source sets the bit, and it stays set until software clears it by writing a one to that position.

A bit is pending when its status bit and its enable bit are both one. When any bit is pending, the block raises the combined request. It also reports the index of the lowest-numbered pending bit, together with a valid flag. Software reaches the two registers over a single-cycle register bus. Reads are combinational in the cycle of the access, and writes take effect at the clock edge. The status register sits at byte offset 0x0 and the enable register at byte offset 0x4.

Top module: `pirq_aggregator`

## Requirements
- R1: After reset, the enable register reads 0, both sticky status bits read 0, and `irq_req`, `pend_valid` and `pend_idx` are all 0.
- R2: A write to offset 0x4 replaces all 32 enable bits at the clock edge, and later reads of 0x4 return exactly the written value. Bit n set to 1 enables source n.
- R3: Reading offset 0x0 returns, at every bit position other than 10 and 11, the current level of the matching input line `src_in[n]`.
- R4: Writes to offset 0x0 leave every status bit other than 10 and 11 unchanged, even when the written value is all ones.
- R5: Status bits 10 and 11 are set in the cycle after a rising edge of their source. They stay set after the source falls.
- R6: Writing 1 to bit 10 or 11 at offset 0x0 clears that sticky bit at the clock edge. Writing 0 to that bit leaves it unchanged.
- R7: If a rising edge on a sticky source and a clearing write to the same bit meet at the same clock edge, the bit ends up set.
- R8: `irq_req` is 1 exactly when the bitwise AND of the status and enable registers is non-zero. A status bit whose enable is 0 never raises it.
- R9: `pend_valid` equals `irq_req`. When `pend_valid` is 1, `pend_idx` (5 bits) holds the lowest bit position set in the pending vector. When nothing is pending, `pend_idx` is 0.
- R10: Reads of any offset other than 0x0 and 0x4 return 0. Writes to such offsets change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 32 | Interrupt lines from the peripherals |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_req | output | 1 | Combined interrupt request |
| pend_valid | output | 1 | Some source is pending |
| pend_idx | output | 5 | Lowest pending source number |

## Verification
The bench writes all ones to the status register while lines are active. A design that forgot which bits are read-only would wipe or latch level bits. A clear is timed to meet a fresh rising edge at the same clock edge; a design where clear wins would lose that event and report 0 on bit 11. The pending index is checked with several sources active at once under different enable patterns, including bit 31 alone. A highest-first encoder, or an encoder that ignores the enables, would give the wrong index. The bench also reads and writes unmapped offsets: decode that aliases on partial address bits would return register contents there or corrupt the enables.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
   localparam int unsigned SRC_COUNT   = 32;
   localparam int unsigned BUS_WIDTH   = 32;
   localparam int unsigned OFFSET_BITS = 4;
   // Positions 10 (serial tx done) and 11 (serial rx done) are sticky.
   localparam logic [SRC_COUNT-1:0] STICKY_DEFAULT = 32'h0000_0C00;
   localparam logic [OFFSET_BITS-1:0] STATUS_OFFSET = 4'h0;
   localparam logic [OFFSET_BITS-1:0] ENABLE_OFFSET = 4'h4;
endpackage

// File: rtl/pirq_sticky_bit.sv
module pirq_sticky_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   input  logic clr_req,
   output logic flag_q
);
   logic line_d;

   // Previous line level. It has no reset so that a line held high through reset gives no edge.
   always_ff @(posedge clk) begin
      line_d <= line_in;
   end

   logic edge_seen;
   assign edge_seen = line_in & ~line_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (edge_seen) begin
         flag_q <= 1'b1;             // a new event takes priority over a clear
      end else if (clr_req) begin
         flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/pirq_status_bank.sv
module pirq_status_bank #(
   parameter int unsigned NUM_SRC = 32,
   parameter logic [NUM_SRC-1:0] STICKY_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic [NUM_SRC-1:0] clr_bits,
   output logic [NUM_SRC-1:0] status_vec
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (STICKY_MASK[i]) begin : g_sticky
         pirq_sticky_bit u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (src_in[i]),
            .clr_req (clr_bits[i]),
            .flag_q  (status_vec[i])
         );
      end else begin : g_level
         logic unused_clr;
         assign unused_clr    = clr_bits[i];
         assign status_vec[i] = src_in[i];
      end
   end
endmodule

// File: rtl/pirq_enable_reg.sv
module pirq_enable_reg #(
   parameter int unsigned NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [NUM_SRC-1:0] load_val,
   output logic [NUM_SRC-1:0] enable_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
      end else if (load) begin
         enable_q <= load_val;
      end
   end
endmodule

// File: rtl/pirq_lowest_enc.sv
module pirq_lowest_enc #(
   parameter int unsigned WIDTH = 32,
   localparam int unsigned IDX_W = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) begin
            idx = IDX_W'(i);
         end
      end
   end

   assign any = |vec;
endmodule

// File: rtl/pirq_aggregator.sv
module pirq_aggregator
   import pirq_pkg::*;
#(
   parameter int unsigned NUM_SRC = SRC_COUNT,
   parameter int unsigned DATA_W  = BUS_WIDTH,
   parameter int unsigned ADDR_W  = OFFSET_BITS,
   parameter logic [NUM_SRC-1:0] STICKY_MASK = STICKY_DEFAULT,
   parameter logic [ADDR_W-1:0]  STS_OFF = STATUS_OFFSET,
   parameter logic [ADDR_W-1:0]  ENA_OFF = ENABLE_OFFSET,
   localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_req,
   output logic              pend_valid,
   output logic [IDX_W-1:0]  pend_idx
);
   // Elaboration-time parameter checks
   if (NUM_SRC < 2) begin : g_err_src
      $error("NUM_SRC must be at least 2");
   end
   if (NUM_SRC > DATA_W) begin : g_err_width
      $error("NUM_SRC must not exceed DATA_W");
   end
   if (STS_OFF == ENA_OFF) begin : g_err_off
      $error("status and enable offsets must differ");
   end

   logic               hit_sts, hit_ena, wr_sts, wr_ena, rd_en;
   logic [NUM_SRC-1:0] wdata_src;
   logic [NUM_SRC-1:0] clr_bits;
   logic [NUM_SRC-1:0] status_vec;
   logic [NUM_SRC-1:0] enable_vec;
   logic [NUM_SRC-1:0] pending_vec;

   assign hit_sts   = (bus_addr == STS_OFF);
   assign hit_ena   = (bus_addr == ENA_OFF);
   assign wr_sts    = bus_sel & bus_wr & hit_sts;
   assign wr_ena    = bus_sel & bus_wr & hit_ena;
   assign rd_en     = bus_sel & ~bus_wr;
   assign wdata_src = bus_wdata[NUM_SRC-1:0];
   assign clr_bits  = wr_sts ? (wdata_src & STICKY_MASK) : '0;

   if (DATA_W > NUM_SRC) begin : g_pad
      logic unused_hi;
      assign unused_hi = ^bus_wdata[DATA_W-1:NUM_SRC];
   end

   pirq_status_bank #(
      .NUM_SRC     (NUM_SRC),
      .STICKY_MASK (STICKY_MASK)
   ) u_status (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_in     (src_in),
      .clr_bits   (clr_bits),
      .status_vec (status_vec)
   );

   pirq_enable_reg #(
      .NUM_SRC (NUM_SRC)
   ) u_enable (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wr_ena),
      .load_val (wdata_src),
      .enable_q (enable_vec)
   );

   assign pending_vec = status_vec & enable_vec;

   pirq_lowest_enc #(
      .WIDTH (NUM_SRC)
   ) u_enc (
      .vec (pending_vec),
      .any (pend_valid),
      .idx (pend_idx)
   );

   assign irq_req = pend_valid;

   always_comb begin
      bus_rdata = '0;
      if (rd_en && hit_sts) begin
         bus_rdata = DATA_W'(status_vec);
      end else if (rd_en && hit_ena) begin
         bus_rdata = DATA_W'(enable_vec);
      end
   end
endmodule

// File: rtl/pirq_aggregator_chk.sv
module pirq_aggregator_chk #(
   parameter int unsigned NUM_SRC = 32,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4,
   parameter logic [NUM_SRC-1:0] STICKY_MASK = '0,
   parameter logic [ADDR_W-1:0]  STS_OFF = '0,
   parameter logic [ADDR_W-1:0]  ENA_OFF = '0,
   localparam int unsigned IDX_W = $clog2(NUM_SRC)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_in,
   input logic               bus_sel,
   input logic               bus_wr,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic               irq_req,
   input logic               pend_valid,
   input logic [IDX_W-1:0]   pend_idx,
   input logic [NUM_SRC-1:0] status_vec,
   input logic [NUM_SRC-1:0] enable_vec
);
   logic [NUM_SRC-1:0] pend_chk;
   logic [NUM_SRC-1:0] below_idx;
   logic               sts_write, ena_write;

   assign pend_chk  = status_vec & enable_vec;
   assign below_idx = (NUM_SRC'(1) << pend_idx) - NUM_SRC'(1);
   assign sts_write = bus_sel && bus_wr && (bus_addr == STS_OFF);
   assign ena_write = bus_sel && bus_wr && (bus_addr == ENA_OFF);

   p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ena_write |=> enable_vec == $past(bus_wdata[NUM_SRC-1:0]));

   p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ena_write |=> $stable(enable_vec));

   p_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req == (pend_chk != '0));

   p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid == irq_req);

   p_idx_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pend_valid |-> (pend_chk[pend_idx] && ((pend_chk & below_idx) == '0)));

   p_idx_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !pend_valid |-> pend_idx == '0);

   p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_wr && bus_addr != STS_OFF && bus_addr != ENA_OFF)
         |-> bus_rdata == '0);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (STICKY_MASK[i]) begin : g_sticky
         p_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(src_in[i]) |=> status_vec[i]);

         p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (status_vec[i] && !(sts_write && bus_wdata[i])) |=> status_vec[i]);

         p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_write && bus_wdata[i] && !$rose(src_in[i])) |=> !status_vec[i]);

         p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_write && bus_wdata[i] && $rose(src_in[i])) |=> status_vec[i]);
      end else begin : g_level
         p_level_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && !bus_wr && bus_addr == STS_OFF) |-> bus_rdata[i] == src_in[i]);
      end
   end
endmodule

bind pirq_aggregator pirq_aggregator_chk #(
   .NUM_SRC     (NUM_SRC),
   .DATA_W      (DATA_W),
   .ADDR_W      (ADDR_W),
   .STICKY_MASK (STICKY_MASK),
   .STS_OFF     (STS_OFF),
   .ENA_OFF     (ENA_OFF)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_in     (src_in),
   .bus_sel    (bus_sel),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .irq_req    (irq_req),
   .pend_valid (pend_valid),
   .pend_idx   (pend_idx),
   .status_vec (status_vec),
   .enable_vec (enable_vec)
);

// File: tb/pirq_aggregator_bench.sv
module pirq_aggregator_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_in = '0;
   logic        bus_sel = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_req;
   logic        pend_valid;
   logic [4:0]  pend_idx;

   int checks = 0;
   int errors = 0;
   logic [31:0] rd;

   localparam logic [3:0]  A_STS = 4'h0;
   localparam logic [3:0]  A_ENA = 4'h4;
   localparam logic [31:0] B10   = 32'h0000_0400;
   localparam logic [31:0] B11   = 32'h0000_0800;

   always #2 clk = ~clk;   // 250 MHz

   pirq_aggregator u_pirq_aggregator (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_in     (src_in),
      .bus_sel    (bus_sel),
      .bus_wr     (bus_wr),
      .bus_addr   (bus_addr),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .irq_req    (irq_req),
      .pend_valid (pend_valid),
      .pend_idx   (pend_idx)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_sel = 1'b0;
   endtask

   function automatic logic [5:0] lowest(input logic [31:0] v);
      for (int i = 31; i >= 0; i--) if (v[i]) lowest = 6'(i);
      if (v == '0) lowest = 6'd32;
   endfunction

   task automatic check_pending(input logic [31:0] sts, input logic [31:0] ena,
                                input string tag);
      logic [31:0] p;
      logic [5:0]  lo;
      p  = sts & ena;
      lo = lowest(p);
      #1;
      check(irq_req == (p != 0), {tag, " R8 irq_req"}, 32'(irq_req), 32'(p != 0));
      check(pend_valid == (p != 0), {tag, " R9 valid"}, 32'(pend_valid), 32'(p != 0));
      check(pend_idx == ((p == 0) ? 5'd0 : lo[4:0]), {tag, " R9 idx"},
            32'(pend_idx), (p == 0) ? 32'd0 : 32'(lo));
   endtask

   task automatic t_reset;
      bus_read(A_ENA, rd);
      check(rd == 0, "R1 enable after reset", rd, 0);
      bus_read(A_STS, rd);
      check(rd == 0, "R1 status after reset", rd, 0);
      check_pending(0, 0, "R1 reset");
   endtask

   task automatic t_mask_rw;
      bus_write(A_ENA, 32'hA5A5_3C3C);
      bus_read(A_ENA, rd);
      check(rd == 32'hA5A5_3C3C, "R2 enable readback", rd, 32'hA5A5_3C3C);
      bus_write(A_ENA, 32'h0000_0000);
      bus_read(A_ENA, rd);
      check(rd == 0, "R2 enable cleared", rd, 0);
   endtask

   task automatic t_level;
      @(negedge clk); src_in = 32'h8001_0003;
      bus_read(A_STS, rd);
      check(rd == 32'h8001_0003, "R3 level follow", rd, 32'h8001_0003);
      check_pending(32'h8001_0003, 0, "R8 masked");
      @(negedge clk); src_in = 32'h0000_00F0;
      bus_read(A_STS, rd);
      check(rd == 32'h0000_00F0, "R3 level follow 2", rd, 32'h0000_00F0);
   endtask

   task automatic t_level_write;
      bus_write(A_STS, 32'hFFFF_FFFF);
      bus_read(A_STS, rd);
      check(rd == 32'h0000_00F0, "R4 write ignored", rd, 32'h0000_00F0);
      @(negedge clk); src_in = 0;
   endtask

   task automatic t_sticky;
      @(negedge clk); src_in = B10;
      @(negedge clk); src_in = B11;      // bit 10 falls, bit 11 rises
      @(negedge clk);
      bus_read(A_STS, rd);
      check(rd == (B10 | B11), "R5 sticky set and held", rd, B10 | B11);
      @(negedge clk); src_in = 0;
      bus_read(A_STS, rd);
      check(rd == (B10 | B11), "R5 held after fall", rd, B10 | B11);
   endtask

   task automatic t_clear;
      bus_write(A_STS, 32'hFFFF_F3FF);   // zeros at 10 and 11
      bus_read(A_STS, rd);
      check(rd == (B10 | B11), "R6 zero write keeps", rd, B10 | B11);
      bus_write(A_STS, B10);
      bus_read(A_STS, rd);
      check(rd == B11, "R6 clear bit 10", rd, B11);
   endtask

   task automatic t_set_wins;
      bus_write(A_STS, B11);
      bus_read(A_STS, rd);
      check(rd == 0, "R6 clear bit 11", rd, 0);
      @(negedge clk);
      src_in = B11;
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_STS; bus_wdata = B11;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      bus_read(A_STS, rd);
      check(rd == B11, "R7 set beats clear", rd, B11);
      @(negedge clk); src_in = 0;
      bus_write(A_STS, B11);
   endtask

   task automatic t_pending;
      bus_write(A_ENA, 32'hFFFF_FFFF);
      check_pending(0, 32'hFFFF_FFFF, "R9 none");
      @(negedge clk); src_in = 32'h8001_0020;
      check_pending(32'h8001_0020, 32'hFFFF_FFFF, "R9 multi");
      bus_write(A_ENA, 32'hFFFF_FFC0);
      check_pending(32'h8001_0020, 32'hFFFF_FFC0, "R9 masked low");
      @(negedge clk); src_in = 32'h8001_0020 | B10;
      @(negedge clk);
      check_pending(32'h8001_0020 | B10, 32'hFFFF_FFC0, "R9 sticky first");
      bus_write(A_ENA, 32'h8000_0000);
      check_pending(32'h8001_0020 | B10, 32'h8000_0000, "R9 bit31");
      bus_write(A_ENA, 32'h0000_0000);
      check_pending(32'h8001_0020 | B10, 0, "R8 all masked");
      @(negedge clk); src_in = 0;
      bus_write(A_STS, B10);
   endtask

   task automatic t_unmapped;
      bus_write(A_ENA, 32'h1234_5678);
      foreach (rd[i]) begin end
      for (int a = 0; a < 16; a++) begin
         if (a != 0 && a != 4) begin
            bus_read(4'(a), rd);
            check(rd == 0, "R10 unmapped read", rd, 0);
         end
      end
      bus_write(4'h8, 32'hFFFF_FFFF);
      bus_write(4'h5, 32'h0000_0000);
      bus_read(A_ENA, rd);
      check(rd == 32'h1234_5678, "R10 unmapped write", rd, 32'h1234_5678);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_mask_rw();
      t_level();
      t_level_write();
      t_sticky();
      t_clear();
      t_set_wins();
      t_pending();
      t_unmapped();
      repeat (2) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule